// File: doc/BRIEF.md
# Four-Lane Clock Output Stage

This block is the digital back end of a clock generator with four outputs. Every lane picks one of several candidate clocks, divides it by a power of two and passes it through a gate. Candidates are the four synthesizer clocks and five raw input-stage clocks: oscillator, reference, divided reference, feedback and divided feedback. The gate decides whether the lane toggles, parks low, parks high or releases the pin. It weighs a per-lane enable bit, a shared enable pin, the PLL lock indicator with a per-lane fault policy, and a per-lane feedback flag that keeps the lane running no matter what.

All candidate clocks are slow relative to the system clock `clk` and are sampled in that domain. Edges are found by comparing each sample with the previous one, so the whole block is one synchronous design. A host writes the lane settings through a plain address, data and strobe port. New divider, source and enable settings are taken up only while the lane's divided clock is low, so the output never carries a shortened high pulse. Each lane also reports whether it can be phase aligned with the others.

Top module: `clkout_stage`

## Requirements
- R1: After reset, lane n selects synthesizer clock n, divides by 1, is enabled, drives its pin (clk_oe high) and reports phase_ok high, so its period equals that of synthesizer clock n.
- R2: The divider field (bits 6:4 of the lane's even register, address 2n) with a code k from 0 to 5 makes the output period 2^k times the period of the selected source.
- R3: Divider codes 6 and 7 behave like code 5, a division by 32.
- R4: Select codes 0 to 3 (bits 3:0 of register 2n) pick synthesizer clock 0 to 3 for any lane, so several lanes can carry the same synthesizer clock.
- R5: Select codes 4 to 8 feed a raw input clock straight into the lane divider, in the order oscillator, reference, divided reference, feedback, divided feedback.
- R6: Select codes 9 to 15 fall back to the lane's own synthesizer clock.
- R7: A lane whose enable bit (bit 7 of register 2n) is 0, or any lane while out_en_all is low, holds its output low with clk_oe high; while the PLL is locked a lane not in a fault state always drives its pin.
- R8: While pll_lock is low, a lane follows its policy field (bits 1:0 of the odd register, address 2n+1): 0 holds low, 1 holds high, 2 or 3 releases the pin (clk_oe low).
- R9: A lane whose feedback flag (bit 2 of register 2n+1) is set keeps toggling with clk_oe high, regardless of its enable bit, out_en_all and pll_lock.
- R10: phase_ok for a lane is high exactly when its applied divider is 1 and its applied source is not a raw input clock.
- R11: Changes to enable, divider or source are applied only while the lane's divided clock is low. A divider or source change restarts the divider from zero on the next rising source edge, so every high pulse of an enabled lane lasts a full divided high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all candidate clocks are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 2n for lane n source/divider/enable, 2n+1 for lane n policy/feedback |
| wr_data | input | 8 | Register write data |
| synth_clk | input | 4 | Synthesizer clocks, one per lane |
| byp_clk | input | 5 | Raw input clocks: oscillator, reference, divided reference, feedback, divided feedback |
| pll_lock | input | 1 | PLL lock indicator, high when locked |
| out_en_all | input | 1 | Shared enable for all lanes, high to enable |
| clk_out | output | 4 | Lane output clocks |
| clk_oe | output | 4 | Lane pin drive enables, low means high impedance |
| phase_ok | output | 4 | Lane can be phase aligned with other lanes |

## Verification
A source level reaches the lane output two clk edges after it is presented: one register samples it and one registers the gated result. The divider counter moves on the same first edge, so divided outputs follow the same two-edge delay, and a loss of lock reaches the pin on the next edge. Register writes land one edge after the strobe. The lane then waits up to half a divided period for a low phase before applying the change, so the bench lets each change settle for several of the longest periods and then measures whole periods between output rising edges, which do not depend on the fixed latency. Level checks on held states start a few cycles after the stimulus. A pulse-width monitor runs across repeated enable and divider changes to catch any shortened high phase.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

  localparam int SEL_W   = 4;
  localparam int DIV_W   = 3;
  localparam int MAX_LOG = 5;
  localparam int CNT_W   = MAX_LOG;

  typedef enum logic [1:0] {
    LOL_LOW  = 2'd0,
    LOL_HIGH = 2'd1,
    LOL_TRI  = 2'd2,
    LOL_TRIB = 2'd3
  } lol_pol_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
    logic             en;
    lol_pol_e         pol;
    logic             fb;
  } outcfg_t;

  // Divider code to applied log2 ratio; anything above MAX_LOG saturates.
  function automatic logic [DIV_W-1:0] div_log(input logic [DIV_W-1:0] code);
    if (int'(code) > MAX_LOG) return DIV_W'(MAX_LOG);
    return code;
  endfunction

  // True when a select code names a raw input-stage clock.
  function automatic logic sel_is_bypass(input logic [SEL_W-1:0] s,
                                         input int nsyn, input int nbyp);
    int k;
    k = int'(s);
    return (k >= nsyn) && (k < nsyn + nbyp);
  endfunction

endpackage

// File: rtl/clkout_regs.sv
module clkout_regs
  import clkout_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  output outcfg_t [NUM_OUT-1:0]    cfg
);

  genvar n;
  generate
    for (n = 0; n < NUM_OUT; n++) begin : g_lane
      outcfg_t r;
      logic    hit_main;
      logic    hit_aux;

      assign hit_main = wr_en && (wr_addr == ADDR_W'(2 * n));
      assign hit_aux  = wr_en && (wr_addr == ADDR_W'(2 * n + 1));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          r.sel <= SEL_W'(n);
          r.div <= '0;
          r.en  <= 1'b1;
          r.pol <= LOL_LOW;
          r.fb  <= 1'b0;
        end else if (hit_main) begin
          r.sel <= wr_data[SEL_W-1:0];
          r.div <= wr_data[6:4];
          r.en  <= wr_data[7];
        end else if (hit_aux) begin
          r.pol <= lol_pol_e'(wr_data[1:0]);
          r.fb  <= wr_data[2];
        end
      end

      assign cfg[n] = r;
    end
  endgenerate

endmodule

// File: rtl/clkout_div.sv
module clkout_div
  import clkout_pkg::*;
#(
  parameter int NSYN = 4,
  parameter int NBYP = 5,
  parameter int IDX  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSYN-1:0]  syn,
  input  logic [NBYP-1:0]  byp,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [DIV_W-1:0] req_log,
  input  logic             req_run,
  output logic             dclk,
  output logic             apply,
  output logic [DIV_W-1:0] act_log,
  output logic [SEL_W-1:0] act_sel,
  output logic             run_act
);

  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] log_q;
  logic             run_q;
  logic             s_d;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic             src_now;
  logic             src_new;
  logic             rise;
  logic             chg;
  logic             dclk_w;

  function automatic logic pick(input logic [SEL_W-1:0] s,
                                input logic [NSYN-1:0] sv,
                                input logic [NBYP-1:0] bv);
    int k;
    k = int'(s);
    if (k < NSYN) return sv[k];
    if (k < NSYN + NBYP) return bv[k - NSYN];
    return sv[IDX];
  endfunction

  assign src_now = pick(sel_q, syn, byp);
  assign src_new = pick(req_sel, syn, byp);
  assign rise    = src_now & ~s_d;

  always_comb begin
    if (log_q == '0) dclk_w = s_d & armed;
    else             dclk_w = cnt[3'(log_q - 3'd1)];
  end

  assign chg   = (sel_q != req_sel) || (log_q != req_log);
  assign apply = !dclk_w && (chg || (run_q != req_run));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= SEL_W'(IDX);
      log_q <= '0;
      run_q <= 1'b0;
      s_d   <= 1'b0;
      armed <= 1'b0;
      cnt   <= '0;
    end else if (apply && chg) begin
      sel_q <= req_sel;
      log_q <= req_log;
      run_q <= req_run;
      s_d   <= src_new;
      armed <= 1'b0;
      cnt   <= '0;
    end else begin
      if (apply) run_q <= req_run;
      s_d <= src_now;
      if (rise) begin
        cnt   <= cnt + 1'b1;
        armed <= 1'b1;
      end
    end
  end

  assign dclk    = dclk_w;
  assign act_log = log_q;
  assign act_sel = sel_q;
  assign run_act = run_q;

endmodule

// File: rtl/clkout_gate.sv
module clkout_gate
  import clkout_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     dclk,
  input  logic     run_act,
  input  logic     lock,
  input  lol_pol_e pol,
  input  logic     fb,
  output logic     clk_o,
  output logic     oe_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_o <= 1'b0;
      oe_o  <= 1'b1;
    end else if (fb) begin
      clk_o <= dclk;
      oe_o  <= 1'b1;
    end else if (!lock) begin
      unique case (pol)
        LOL_LOW:  begin clk_o <= 1'b0; oe_o <= 1'b1; end
        LOL_HIGH: begin clk_o <= 1'b1; oe_o <= 1'b1; end
        default:  begin clk_o <= 1'b0; oe_o <= 1'b0; end
      endcase
    end else if (run_act) begin
      clk_o <= dclk;
      oe_o  <= 1'b1;
    end else begin
      clk_o <= 1'b0;
      oe_o  <= 1'b1;
    end
  end

endmodule

// File: rtl/clkout_stage.sv
module clkout_stage
  import clkout_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int NUM_BYP = 5,
  parameter int DATA_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [$clog2(NUM_OUT*2)-1:0] wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [NUM_OUT-1:0]           synth_clk,
  input  logic [NUM_BYP-1:0]           byp_clk,
  input  logic                         pll_lock,
  input  logic                         out_en_all,
  output logic [NUM_OUT-1:0]           clk_out,
  output logic [NUM_OUT-1:0]           clk_oe,
  output logic [NUM_OUT-1:0]           phase_ok
);

  localparam int ADDR_W = $clog2(NUM_OUT * 2);

  outcfg_t [NUM_OUT-1:0] cfg;

  // Named internal events for the checker.
  logic [NUM_OUT-1:0]            lane_dclk;
  logic [NUM_OUT-1:0]            lane_apply;
  logic [NUM_OUT-1:0]            lane_fb;
  logic [NUM_OUT-1:0][1:0]       lane_pol;
  logic [NUM_OUT-1:0][DIV_W-1:0] lane_log;

  clkout_regs #(
    .NUM_OUT (NUM_OUT),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg     (cfg)
  );

  genvar n;
  generate
    for (n = 0; n < NUM_OUT; n++) begin : g_out
      logic             dclk;
      logic             apply;
      logic [DIV_W-1:0] act_log;
      logic [SEL_W-1:0] act_sel;
      logic             run_act;

      clkout_div #(
        .NSYN (NUM_OUT),
        .NBYP (NUM_BYP),
        .IDX  (n)
      ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .syn     (synth_clk),
        .byp     (byp_clk),
        .req_sel (cfg[n].sel),
        .req_log (div_log(cfg[n].div)),
        .req_run (cfg[n].en & out_en_all),
        .dclk    (dclk),
        .apply   (apply),
        .act_log (act_log),
        .act_sel (act_sel),
        .run_act (run_act)
      );

      clkout_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .dclk    (dclk),
        .run_act (run_act),
        .lock    (pll_lock),
        .pol     (cfg[n].pol),
        .fb      (cfg[n].fb),
        .clk_o   (clk_out[n]),
        .oe_o    (clk_oe[n])
      );

      assign phase_ok[n]   = (act_log == '0) && !sel_is_bypass(act_sel, NUM_OUT, NUM_BYP);
      assign lane_dclk[n]  = dclk;
      assign lane_apply[n] = apply;
      assign lane_fb[n]    = cfg[n].fb;
      assign lane_pol[n]   = cfg[n].pol;
      assign lane_log[n]   = act_log;
    end
  endgenerate

endmodule

// File: rtl/clkout_stage_chk.sv
module clkout_stage_chk #(
  parameter int NUM_OUT = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     pll_lock,
  input logic [NUM_OUT-1:0]       clk_out,
  input logic [NUM_OUT-1:0]       clk_oe,
  input logic [NUM_OUT-1:0]       lane_dclk,
  input logic [NUM_OUT-1:0]       lane_apply,
  input logic [NUM_OUT-1:0]       lane_fb,
  input logic [NUM_OUT-1:0][1:0]  lane_pol,
  input logic [NUM_OUT-1:0][2:0]  lane_log
);

  genvar i;
  generate
    for (i = 0; i < NUM_OUT; i++) begin : g_chk
      p_apply_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lane_apply[i] |-> !lane_dclk[i]);

      p_div_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lane_log[i] <= 3'd5);

      p_fb_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lane_fb[i] |=> (clk_oe[i] && (clk_out[i] == $past(lane_dclk[i]))));

      p_lol_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pll_lock && !lane_fb[i] && (lane_pol[i] == 2'd1)) |=> (clk_out[i] && clk_oe[i]));

      p_lol_tri_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pll_lock && !lane_fb[i] && lane_pol[i][1]) |=> !clk_oe[i]);

      p_locked_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_lock && !lane_fb[i]) |=> clk_oe[i]);
    end
  endgenerate

endmodule

bind clkout_stage clkout_stage_chk #(.NUM_OUT(NUM_OUT)) u_chk (.*);

// File: tb/clkout_stage_bench.sv
module clkout_stage_bench;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [3:0] synth_clk;
  logic [4:0] byp_clk;
  logic       pll_lock;
  logic       out_en_all;
  logic [3:0] clk_out;
  logic [3:0] clk_oe;
  logic [3:0] phase_ok;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  clkout_stage u_clkout_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .synth_clk  (synth_clk),
    .byp_clk    (byp_clk),
    .pll_lock   (pll_lock),
    .out_en_all (out_en_all),
    .clk_out    (clk_out),
    .clk_oe     (clk_oe),
    .phase_ok   (phase_ok)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Source half periods in clk cycles: synth i -> i+2, raw input j -> j+6.
  int sc[4];
  int bc[5];
  always @(negedge clk) begin
    if (!rst_n) begin
      synth_clk <= '0;
      byp_clk   <= '0;
      for (int i = 0; i < 4; i++) sc[i] <= 0;
      for (int j = 0; j < 5; j++) bc[j] <= 0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (sc[i] == i + 1) begin sc[i] <= 0; synth_clk[i] <= ~synth_clk[i]; end
        else sc[i] <= sc[i] + 1;
      end
      for (int j = 0; j < 5; j++) begin
        if (bc[j] == j + 5) begin bc[j] <= 0; byp_clk[j] <= ~byp_clk[j]; end
        else bc[j] <= bc[j] + 1;
      end
    end
  end

  // Pulse-width monitor on lane 0 for R11.
  bit mon_en   = 0;
  int mon_min  = 0;
  int mon_hl   = 0;
  int mon_runt = 0;
  int mon_puls = 0;
  bit mon_seen = 0;
  logic mon_prev = 1'b0;
  always @(negedge clk) begin
    if (!mon_en) begin
      mon_hl   <= 0;
      mon_seen <= 0;
    end else begin
      if (clk_out[0]) begin
        mon_hl <= mon_hl + 1;
        if (!mon_prev) mon_seen <= 1;
      end else if (mon_prev) begin
        if (mon_seen) begin
          mon_puls <= mon_puls + 1;
          if (mon_hl < mon_min) mon_runt <= mon_runt + 1;
        end
        mon_hl <= 0;
      end
    end
    mon_prev <= clk_out[0];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 3'(addr);
    wr_data = 8'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic idle(input int cyc);
    repeat (cyc) @(negedge clk);
  endtask

  task automatic meas(input int n, output int p);
    logic last;
    bit   found;
    int   t;
    p = -1;
    found = 0;
    @(negedge clk);
    last = clk_out[n];
    for (t = 0; t < 4000 && !found; t++) begin
      @(negedge clk);
      if (clk_out[n] && !last) found = 1;
      last = clk_out[n];
    end
    if (found) begin
      found = 0;
      for (t = 1; t < 4000 && !found; t++) begin
        @(negedge clk);
        if (clk_out[n] && !last) begin found = 1; p = t; end
        last = clk_out[n];
      end
    end
  endtask

  task automatic chk_period(input int n, input int exp, input string tag);
    int p;
    meas(n, p);
    chk(p == exp, tag, p, exp);
  endtask

  task automatic hold(input int n, input int cyc, input logic ev, input logic eoe, input string tag);
    int bad;
    bad = 0;
    for (int c = 0; c < cyc; c++) begin
      @(negedge clk);
      if (clk_out[n] !== ev || clk_oe[n] !== eoe) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic t_reset;
    idle(100);
    for (int n = 0; n < 4; n++) chk_period(n, 2 * (n + 2), "R1 reset period");
    chk(phase_ok == 4'hF, "R1 reset phase_ok", int'(phase_ok), 15);
    chk(clk_oe == 4'hF, "R1 reset clk_oe", int'(clk_oe), 15);
  endtask

  task automatic t_divider;
    for (int k = 0; k <= 5; k++) begin
      wr(0, 8'h80 | (k << 4));
      idle(300);
      chk_period(0, 4 << k, "R2 divider period");
      chk(phase_ok[0] == (k == 0), "R10 phase_ok vs divider", int'(phase_ok[0]), int'(k == 0));
    end
  endtask

  task automatic t_clamp;
    wr(0, 8'hE0);
    idle(300);
    chk_period(0, 128, "R3 divider code 6");
    wr(0, 8'hF0);
    idle(300);
    chk_period(0, 128, "R3 divider code 7");
    wr(0, 8'h80);
    idle(300);
    chk_period(0, 4, "R2 divider back to 1");
  endtask

  task automatic t_fanout;
    wr(4, 8'h80);
    wr(6, 8'h81);
    idle(100);
    chk_period(2, 4, "R4 lane 2 on synth 0");
    chk_period(3, 6, "R4 lane 3 on synth 1");
    chk_period(0, 4, "R4 lane 0 still synth 0");
    chk(phase_ok[2] == 1'b1, "R10 fan-out keeps phase_ok", int'(phase_ok[2]), 1);
    wr(4, 8'h82);
    wr(6, 8'h83);
    idle(100);
    chk_period(2, 8, "R4 lane 2 restored");
  endtask

  task automatic t_bypass;
    for (int s = 4; s <= 8; s++) begin
      wr(2, 8'h80 | s);
      idle(100);
      chk_period(1, 2 * (s + 2), "R5 raw input select");
      chk(phase_ok[1] == 1'b0, "R10 bypass clears phase_ok", int'(phase_ok[1]), 0);
    end
    wr(2, 8'h81);
    idle(100);
    chk(phase_ok[1] == 1'b1, "R10 phase_ok back", int'(phase_ok[1]), 1);
  endtask

  task automatic t_unused;
    wr(6, 8'h89);
    idle(100);
    chk_period(3, 10, "R6 code 9 falls back");
    wr(6, 8'h8F);
    idle(100);
    chk_period(3, 10, "R6 code 15 falls back");
    chk(phase_ok[3] == 1'b1, "R6 fallback is a synth source", int'(phase_ok[3]), 1);
    wr(6, 8'h83);
    idle(50);
  endtask

  task automatic t_enable;
    wr(0, 8'h00);
    idle(20);
    hold(0, 40, 1'b0, 1'b1, "R7 enable bit low holds lane 0");
    chk_period(1, 6, "R7 other lane unaffected");
    wr(0, 8'h80);
    idle(20);
    chk_period(0, 4, "R7 lane 0 re-enabled");
    @(negedge clk) out_en_all = 1'b0;
    idle(20);
    for (int n = 0; n < 4; n++) hold(n, 20, 1'b0, 1'b1, "R7 global pin low");
    @(negedge clk) out_en_all = 1'b1;
    idle(20);
    chk_period(3, 10, "R7 global pin restored");
  endtask

  task automatic t_lock;
    wr(1, 8'h00);
    wr(3, 8'h01);
    wr(5, 8'h02);
    wr(7, 8'h03);
    @(negedge clk) pll_lock = 1'b0;
    idle(3);
    hold(0, 20, 1'b0, 1'b1, "R8 policy hold low");
    hold(1, 20, 1'b1, 1'b1, "R8 policy hold high");
    hold(2, 20, 1'b0, 1'b0, "R8 policy release code 2");
    hold(3, 20, 1'b0, 1'b0, "R8 policy release code 3");
    @(negedge clk) pll_lock = 1'b1;
    wr(1, 0); wr(3, 0); wr(5, 0); wr(7, 0);
    idle(20);
    chk_period(2, 8, "R8 lane toggles after relock");
    chk(clk_oe == 4'hF, "R8 pins driven after relock", int'(clk_oe), 15);
  endtask

  task automatic t_feedback;
    int bad;
    wr(7, 8'h06);
    wr(6, 8'h03);
    @(negedge clk);
    out_en_all = 1'b0;
    pll_lock   = 1'b0;
    idle(20);
    chk_period(3, 10, "R9 feedback lane keeps toggling");
    bad = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (clk_oe[3] !== 1'b1) bad++;
    end
    chk(bad == 0, "R9 feedback lane drives pin", bad, 0);
    hold(0, 20, 1'b0, 1'b1, "R9 non-feedback lane still parked");
    @(negedge clk);
    out_en_all = 1'b1;
    pll_lock   = 1'b1;
    wr(7, 8'h00);
    wr(6, 8'h83);
    idle(50);
  endtask

  task automatic t_runt;
    wr(0, 8'h90);
    idle(100);
    mon_min = 4;
    mon_en  = 1;
    for (int k = 0; k < 8; k++) begin
      wr(0, 8'h10);
      idle(3 + k);
      wr(0, 8'h90);
      idle(5 + 2 * k);
    end
    for (int k = 0; k < 4; k++) begin
      wr(0, 8'hA0);
      idle(7 + k);
      wr(0, 8'h90);
      idle(9 + k);
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk) out_en_all = 1'b0;
      idle(2 + k);
      @(negedge clk) out_en_all = 1'b1;
      idle(11 + k);
    end
    idle(40);
    mon_en = 0;
    chk(mon_runt == 0, "R11 no shortened high pulse", mon_runt, 0);
    chk(mon_puls >= 5, "R11 pulses seen during changes", mon_puls, 5);
    wr(0, 8'h80);
    idle(50);
  endtask

  initial begin
    rst_n      = 1'b0;
    wr_en      = 1'b0;
    wr_addr    = '0;
    wr_data    = '0;
    pll_lock   = 1'b1;
    out_en_all = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_divider();
    t_clamp();
    t_fanout();
    t_bypass();
    t_unused();
    t_enable();
    t_lock();
    t_feedback();
    t_runt();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule